// File: doc/BRIEF.md
# Single-Accumulator Two-Phase Processor

This block is a very small stored-program processor. One memory array holds both the program and its data. A 16-bit accumulator is the only data register the program can see. Each instruction word combines a 3-bit operation code with a 13-bit direct memory address. The core runs each instruction in two clock cycles. In the first cycle it latches the word at the program counter. In the second cycle it carries out the operation against the addressed memory word. It repeats this until it meets a halt instruction, and then it freezes.

The program image is written into memory through a load port that is active only while reset is held. After reset is released, execution begins at address 0. The surrounding logic watches the accumulator and the halted flag to collect the result of the program.

Top module: `acc_cpu`

## Requirements
- R1: An instruction word holds its operation code in bits [2:0] and a direct operand address in bits [15:3]. Memory is indexed by that address modulo MEM_WORDS, so an address of MEM_WORDS+k reaches word k.
- R2: While rst is high at a clock edge, the program counter is set to 0, the accumulator to 0, halted to 0, and the core goes back to fetch. Memory contents are kept across a reset.
- R3: Every instruction takes exactly two clock cycles: a fetch cycle that leaves the accumulator unchanged, then an execute cycle whose result is visible after its clock edge.
- R4: Code 001 adds mem[addr] to the accumulator modulo 2^16.
- R5: Code 010 subtracts mem[addr] from the accumulator modulo 2^16.
- R6: Code 011 writes the accumulator into mem[addr] and leaves the accumulator unchanged.
- R7: Code 101 loads mem[addr] into the accumulator.
- R8: Code 100 does nothing except advance the program counter by one.
- R9: Code 110 sets the program counter to addr.
- R10: Code 111 sets the program counter to addr when the accumulator is zero at execution; otherwise the program counter advances by one.
- R11: Code 000 raises halted at the end of its execute cycle. From then until the next reset, halted stays high and the accumulator, program counter and memory do not change.
- R12: The loop that adds 100 down to 1 (801 instructions) leaves 5050 in the accumulator, and halted rises exactly 1602 clock cycles after reset is released.
- R13: Writes on the load port (ld_en, ld_addr, ld_data) take effect only while rst is high. When rst is low they are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; also enables the load port |
| ld_en | input | 1 | Write strobe for loading the memory image during reset |
| ld_addr | input | 13 | Word address for an image write |
| ld_data | input | 16 | Word value for an image write |
| halted | output | 1 | High once a halt instruction has executed |
| acc | output | 16 | Current accumulator value |

## Verification
The bench builds the core with DATA_W=16 and MEM_WORDS=64. With a 64-word memory, the load phase can write every word before each run, so the core never reads an unwritten location. It also makes address aliasing cheap to reach: an operand address of 107 must land on word 43. A behavioural model is stepped on every clock edge and compared with the accumulator and the halted flag. Directed programs cover wraparound in both directions, a conditional branch that is taken and one that is not, the no-op, the freeze after halt, a load attempt outside reset, and the exact 1602-cycle length of the summation loop.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPC_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_HALT  = 3'b000,
        OP_ADD   = 3'b001,
        OP_SUB   = 3'b010,
        OP_STORE = 3'b011,
        OP_SKIP  = 3'b100,
        OP_LOAD  = 3'b101,
        OP_JUMP  = 3'b110,
        OP_JZERO = 3'b111
    } opcode_e;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_STOP  = 2'd2
    } phase_e;

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
    parameter int WORD_W = 16,
    parameter int WORDS  = 2048,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word
);

    logic [WORD_W-1:0] cells_q [WORDS];

    // Read is combinational, so fetch and operand access each fit in one cycle.
    assign rd_word = cells_q[rd_idx];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells_q[wr_idx] <= wr_word;
        end
    end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  opcode_e           op,
    input  logic [WORD_W-1:0] acc_in,
    input  logic [WORD_W-1:0] operand,
    output logic [WORD_W-1:0] acc_out,
    output logic              acc_zero
);

    always_comb begin
        unique case (op)
            OP_ADD:  acc_out = acc_in + operand;
            OP_SUB:  acc_out = acc_in - operand;
            OP_LOAD: acc_out = operand;
            default: acc_out = acc_in;
        endcase
    end

    assign acc_zero = (acc_in == '0);

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int MEM_WORDS = 2048
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ld_en,
    input  logic [DATA_W-OPC_W-1:0] ld_addr,
    input  logic [DATA_W-1:0]       ld_data,
    output logic                    halted,
    output logic [DATA_W-1:0]       acc
);

    localparam int ARG_W  = DATA_W - OPC_W;
    localparam int MEM_AW = $clog2(MEM_WORDS);

    typedef struct packed {
        phase_e            phase;
        logic [ARG_W-1:0]  pc;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] acc;
    } core_t;

    core_t cur_q, nxt_d;

    phase_e            phase_q;
    logic [ARG_W-1:0]  pc_q;
    logic [DATA_W-1:0] ir_q;
    opcode_e           op;
    logic [ARG_W-1:0]  arg;
    logic [ARG_W-1:0]  pc_inc;

    logic [MEM_AW-1:0] rd_idx;
    logic [DATA_W-1:0] rd_word;
    logic              wr_en;
    logic [MEM_AW-1:0] wr_idx;
    logic [DATA_W-1:0] wr_word;

    logic [DATA_W-1:0] alu_acc;
    logic              acc_zero;

    assign phase_q = cur_q.phase;
    assign pc_q    = cur_q.pc;
    assign ir_q    = cur_q.ir;
    assign op      = opcode_e'(cur_q.ir[OPC_W-1:0]);
    assign arg     = cur_q.ir[DATA_W-1:OPC_W];
    assign pc_inc  = cur_q.pc + 1'b1;

    // A single read port: program counter during fetch, operand address during execute.
    assign rd_idx = (cur_q.phase == ST_FETCH) ? cur_q.pc[MEM_AW-1:0] : arg[MEM_AW-1:0];

    // The image load owns the write port while reset is held; store owns it otherwise.
    always_comb begin
        if (rst) begin
            wr_en   = ld_en;
            wr_idx  = ld_addr[MEM_AW-1:0];
            wr_word = ld_data;
        end else begin
            wr_en   = (cur_q.phase == ST_EXEC) && (op == OP_STORE);
            wr_idx  = arg[MEM_AW-1:0];
            wr_word = cur_q.acc;
        end
    end

    acc_cpu_mem #(
        .WORD_W (DATA_W),
        .WORDS  (MEM_WORDS)
    ) u_mem (
        .clk     (clk),
        .rd_idx  (rd_idx),
        .rd_word (rd_word),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_word (wr_word)
    );

    acc_cpu_alu #(
        .WORD_W (DATA_W)
    ) u_alu (
        .op       (op),
        .acc_in   (cur_q.acc),
        .operand  (rd_word),
        .acc_out  (alu_acc),
        .acc_zero (acc_zero)
    );

    always_comb begin
        nxt_d = cur_q;
        if (rst) begin
            nxt_d.phase = ST_FETCH;
            nxt_d.pc    = '0;
            nxt_d.ir    = '0;
            nxt_d.acc   = '0;
        end else begin
            unique case (cur_q.phase)
                ST_FETCH: begin
                    nxt_d.ir    = rd_word;
                    nxt_d.phase = ST_EXEC;
                end
                ST_EXEC: begin
                    nxt_d.phase = ST_FETCH;
                    nxt_d.pc    = pc_inc;
                    nxt_d.acc   = alu_acc;
                    unique case (op)
                        OP_HALT: begin
                            nxt_d.phase = ST_STOP;
                            nxt_d.pc    = cur_q.pc;
                        end
                        OP_JUMP:  nxt_d.pc = arg;
                        OP_JZERO: if (acc_zero) nxt_d.pc = arg;
                        default:  ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    assign halted = (cur_q.phase == ST_STOP);
    assign acc    = cur_q.acc;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ARG_W  = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              halted,
    input logic [DATA_W-1:0] acc,
    input phase_e            phase_q,
    input logic [ARG_W-1:0]  pc_q,
    input logic [DATA_W-1:0] ir_q
);

    logic             in_exec;
    logic [ARG_W-1:0] ir_arg;
    assign in_exec = (phase_q == ST_EXEC);
    assign ir_arg  = ir_q[DATA_W-1:OPC_W];

    p_reset_clear_r2: assert property (@(posedge clk)
        rst |=> (acc == '0 && !halted && pc_q == '0 && phase_q == ST_FETCH));

    p_fetch_then_exec_r3: assert property (@(posedge clk) disable iff (rst)
        phase_q == ST_FETCH |=> phase_q == ST_EXEC);

    p_fetch_keeps_acc_r3: assert property (@(posedge clk) disable iff (rst)
        phase_q == ST_FETCH |=> $stable(acc));

    p_store_keeps_acc_r6: assert property (@(posedge clk) disable iff (rst)
        (in_exec && ir_q[OPC_W-1:0] == OP_STORE) |=> $stable(acc));

    p_skip_steps_r8: assert property (@(posedge clk) disable iff (rst)
        (in_exec && ir_q[OPC_W-1:0] == OP_SKIP)
            |=> ($stable(acc) && pc_q == $past(pc_q) + 1'b1));

    p_jump_target_r9: assert property (@(posedge clk) disable iff (rst)
        (in_exec && ir_q[OPC_W-1:0] == OP_JUMP) |=> pc_q == $past(ir_arg));

    p_jz_taken_r10: assert property (@(posedge clk) disable iff (rst)
        (in_exec && ir_q[OPC_W-1:0] == OP_JZERO && acc == '0) |=> pc_q == $past(ir_arg));

    p_jz_fall_r10: assert property (@(posedge clk) disable iff (rst)
        (in_exec && ir_q[OPC_W-1:0] == OP_JZERO && acc != '0)
            |=> pc_q == $past(pc_q) + 1'b1);

    p_halt_enter_r11: assert property (@(posedge clk) disable iff (rst)
        (in_exec && ir_q[OPC_W-1:0] == OP_HALT) |=> halted);

    p_halt_frozen_r11: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(acc) && $stable(pc_q)));

endmodule

bind acc_cpu acc_cpu_chk #(
    .DATA_W (DATA_W),
    .ARG_W  (ARG_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .halted  (halted),
    .acc     (acc),
    .phase_q (phase_q),
    .pc_q    (pc_q),
    .ir_q    (ir_q)
);

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int AW = 13;
    localparam int MW = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;
    logic          halted;
    logic [DW-1:0] acc;

    int n_tests = 0;
    int n_fail  = 0;
    bit cmp_on  = 1'b0;

    logic [DW-1:0] img   [MW];
    logic [DW-1:0] m_mem [MW];
    int            m_pc    = 0;
    int            m_phase = 0;
    logic [DW-1:0] m_acc   = '0;
    bit            m_halt  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_cpu #(
        .DATA_W    (DW),
        .MEM_WORDS (MW)
    ) u_dut (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .halted  (halted),
        .acc     (acc)
    );

    function automatic logic [DW-1:0] enc(input logic [2:0] op, input int addr);
        return {addr[AW-1:0], op};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: one step per rising edge.
    always @(posedge clk) begin
        if (rst) begin
            if (ld_en) m_mem[int'(ld_addr) % MW] = ld_data;
            m_pc = 0; m_acc = '0; m_phase = 0; m_halt = 1'b0;
        end else if (!m_halt) begin
            if (m_phase == 0) begin
                m_phase = 1;
            end else begin
                logic [DW-1:0] w;
                int a;
                w = m_mem[m_pc % MW];
                a = int'(w[DW-1:3]) % MW;
                m_phase = 0;
                m_pc = (m_pc + 1) % (1 << AW);
                case (w[2:0])
                    3'b000: m_halt = 1'b1;
                    3'b001: m_acc = m_acc + m_mem[a];
                    3'b010: m_acc = m_acc - m_mem[a];
                    3'b011: m_mem[a] = m_acc;
                    3'b101: m_acc = m_mem[a];
                    3'b110: m_pc = int'(w[DW-1:3]);
                    3'b111: if (m_acc == '0) m_pc = int'(w[DW-1:3]);
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            check(acc === m_acc, "R3 model acc", acc, m_acc);
            check(halted === m_halt, "R11 model halted", halted, m_halt);
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_image();
        for (int i = 0; i < MW; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_addr = AW'(i); ld_data = img[i];
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic clear_image();
        for (int i = 0; i < MW; i++) img[i] = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        cycles(3);
        check(acc === 16'h0, "R2 reset acc", acc, 0);
        check(halted === 1'b0, "R2 reset halted", halted, 0);

        // Directed program: wrap, store/load, aliasing, branches, no-op, halt.
        clear_image();
        img[0]  = enc(3'b101, 40);
        img[1]  = enc(3'b001, 41);
        img[2]  = enc(3'b010, 42);
        img[3]  = enc(3'b011, 43);
        img[4]  = enc(3'b101, 44);
        img[5]  = enc(3'b111, 7);
        img[6]  = enc(3'b000, 0);
        img[7]  = enc(3'b101, 43 + MW);
        img[8]  = enc(3'b111, 10);
        img[9]  = enc(3'b100, 41);
        img[10] = enc(3'b110, 12);
        img[11] = enc(3'b000, 0);
        img[12] = enc(3'b001, 41);
        img[13] = enc(3'b000, 0);
        img[40] = 16'hFFFF;
        img[41] = 16'h0002;
        img[42] = 16'h0003;
        img[44] = 16'h0000;
        load_image();
        rst = 1'b0;
        cmp_on = 1'b1;

        cycles(1);
        check(acc === 16'h0, "R3 fetch leaves acc", acc, 0);
        cycles(1);
        check(acc === 16'hFFFF, "R7 load", acc, 16'hFFFF);
        cycles(2);
        check(acc === 16'h0001, "R4 add wraps", acc, 16'h0001);
        cycles(2);
        check(acc === 16'hFFFE, "R5 sub wraps", acc, 16'hFFFE);
        cycles(2);
        check(acc === 16'hFFFE, "R6 store keeps acc", acc, 16'hFFFE);
        cycles(2);
        check(acc === 16'h0000, "R7 load zero", acc, 0);
        cycles(2);
        check(halted === 1'b0, "R10 jz taken", halted, 0);
        cycles(2);
        check(halted === 1'b0, "R10 jz skipped halt", halted, 0);
        check(acc === 16'hFFFE, "R1 R6 aliased load of stored word", acc, 16'hFFFE);
        cycles(2);
        check(acc === 16'hFFFE, "R10 jz not taken", acc, 16'hFFFE);
        cycles(2);
        check(acc === 16'hFFFE, "R8 no-op", acc, 16'hFFFE);
        check(halted === 1'b0, "R8 no-op advances", halted, 0);
        cycles(2);
        cycles(2);
        check(acc === 16'h0000, "R9 jump skipped halt", acc, 0);
        check(halted === 1'b0, "R9 still running", halted, 0);
        cycles(2);
        check(halted === 1'b1, "R11 halt", halted, 1);

        // Load attempt while running state is frozen and rst is low.
        ld_en = 1'b1; ld_addr = AW'(41); ld_data = 16'h0005;
        cycles(1);
        ld_en = 1'b0;
        cycles(10);
        check(halted === 1'b1, "R11 halt sticky", halted, 1);
        check(acc === 16'h0000, "R11 acc frozen", acc, 0);

        // Re-run without reloading: memory kept, stray load ignored.
        rst = 1'b1;
        cycles(2);
        check(acc === 16'h0000, "R2 reset clears acc", acc, 0);
        check(halted === 1'b0, "R2 reset clears halted", halted, 0);
        rst = 1'b0;
        cycles(2);
        check(acc === 16'hFFFF, "R2 memory kept over reset", acc, 16'hFFFF);
        cycles(2);
        check(acc === 16'h0001, "R13 load port ignored outside reset", acc, 16'h0001);

        // Summation loop.
        rst = 1'b1;
        cycles(1);
        clear_image();
        img[0]  = enc(3'b101, 10);
        img[1]  = enc(3'b001, 11);
        img[2]  = enc(3'b011, 10);
        img[3]  = enc(3'b101, 11);
        img[4]  = enc(3'b010, 12);
        img[5]  = enc(3'b011, 11);
        img[6]  = enc(3'b111, 8);
        img[7]  = enc(3'b110, 0);
        img[8]  = enc(3'b101, 10);
        img[9]  = enc(3'b000, 0);
        img[10] = 16'd0;
        img[11] = 16'd100;
        img[12] = 16'd1;
        load_image();
        rst = 1'b0;
        cycles(1601);
        check(halted === 1'b0, "R12 not halted at 1601", halted, 0);
        cycles(1);
        check(halted === 1'b1, "R12 halted at 1602", halted, 1);
        check(acc === 16'd5050, "R12 sum", acc, 16'd5050);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule